// File: doc/BRIEF.md
# Management Mailbox Responder Register Bank

This block is the target end of a byte-addressed management mailbox. An external initiator reaches it through a plain byte-wide register port. The serial bus that would normally carry those accesses sits outside the block. The initiator loads a command byte and a 32-bit argument into an inbound message window, then rings a doorbell register. Firmware sees the doorbell as a service-request flag, together with the latched command and argument.

When firmware finishes, it pulses a completion strobe that carries the echoed command, a 32-bit result word and a return code. The block copies these into an outbound message window that the initiator can only read. The same strobe sets a sticky alert status bit. That bit drives an interrupt output toward the initiator when an enable bit allows it. The initiator acknowledges by writing a one to the status bit, and firmware drops the doorbell through a separate acknowledge input.

Top module: `mbox_target_bank`

## Requirements
- R1: The inbound window at 0x38..0x3F is read/write from the host port. Read data appears on `hst_rdata` in the cycle after `hst_re` and holds until the next read. After reset every inbound byte reads 0x00, except 0x3F, which reads 0x80.
- R2: `fw_cmd` always equals inbound byte 0x38. `fw_arg` is {0x3C,0x3B,0x3A,0x39}, so byte 0x39 is the least significant.
- R3: A host write to the doorbell at 0x40 loads bit 0 of the write data. Writing 0x01 raises `fw_req` and writing 0x00 drops it, both from the next cycle. A read of 0x40 returns {7'b0, doorbell}. The doorbell resets to 0.
- R4: A pulse on `fw_ack` clears the doorbell. If a host write to 0x40 lands in the same cycle, the host write decides the new value.
- R5: A pulse on `fw_done` loads the outbound window at 0x30..0x37 as follows:
  - 0x30 takes `fw_done_cmd`.
  - 0x31..0x34 take `fw_done_data`, least significant byte first.
  - 0x35 and 0x36 become 0x00.
  - 0x37 takes `fw_done_code`.

  Host writes to 0x30..0x37 change nothing.
- R6: The return code byte at 0x37 is stored unaltered. The defined values are 0 for success, 1 for aborted, 2 for unknown command and 3 for invalid core.
- R7: `fw_done` sets the alert bit, which is bit 1 of status register 0x02. The bit stays set until the host clears it. A read of 0x02 returns {6'b0, alert, 1'b0}.
- R8: A host write to 0x02 with bit 1 set clears the alert bit. A write with bit 1 clear leaves it unchanged.
- R9: If `fw_done` and a clearing host write to 0x02 fall in the same cycle, the alert bit ends up set.
- R10: The enable bit is bit 0 of register 0x03 and resets to 1. `irq_alert` is high exactly while the alert bit and the enable are both set. Clearing the enable masks `irq_alert` but leaves the status bit as it was.
- R11: Reads of any address outside 0x02, 0x03, 0x30..0x3F and 0x40 return 0x00. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered host read data |
| fw_req | output | 1 | Service request (doorbell) to firmware |
| fw_cmd | output | 8 | Latched command byte |
| fw_arg | output | 32 | Latched argument word |
| fw_ack | input | 1 | Firmware clears the doorbell |
| fw_done | input | 1 | Firmware completion strobe |
| fw_done_cmd | input | 8 | Echoed command at completion |
| fw_done_data | input | 32 | Result word at completion |
| fw_done_code | input | 8 | Return code at completion |
| irq_alert | output | 1 | Alert interrupt toward the initiator |

## Verification
Every register effect lands on the clock edge that samples the stimulus. Host writes, `fw_ack` and `fw_done` are therefore visible on `fw_req`, `fw_cmd`, `fw_arg` and `irq_alert` one cycle later, and those outputs are checked at the next falling edge. A read returns its byte exactly one cycle after `hst_re`. The read driver queues the expected byte, and a monitor compares it at the falling edge that follows the sampling edge, so a missing or extra pipeline stage shows up as a mismatch. Same-cycle collisions, the doorbell against `fw_ack` and the alert set against its clear, are driven in a single cycle and judged in the next.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] ADDR_STATUS    = 8'h02;
    localparam logic [7:0] ADDR_ALERT_CTL = 8'h03;
    localparam logic [7:0] ADDR_OUT_BASE  = 8'h30;
    localparam logic [7:0] ADDR_IN_BASE   = 8'h38;
    localparam logic [7:0] ADDR_DOORBELL  = 8'h40;
    localparam int         ALERT_BIT      = 1;
    localparam logic [7:0] IN_LAST_RESET  = 8'h80;
endpackage

// File: rtl/mbox_inbound.sv
module mbox_inbound
    import mbox_pkg::*;
#(
    parameter int MSG_BYTES = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [7:0]                         wr_addr,
    input  logic [BYTE_W-1:0]                  wr_data,
    input  logic                               ack,
    output logic [MSG_BYTES-1:0][BYTE_W-1:0]   in_bytes,
    output logic                               door
);
    typedef struct packed {
        logic [MSG_BYTES-1:0][BYTE_W-1:0] msg;
        logic                             door;
    } in_st_t;

    in_st_t st_d, st_q;

    function automatic in_st_t in_reset();
        in_st_t s;
        s.msg                = '0;
        s.msg[MSG_BYTES-1]   = IN_LAST_RESET;
        s.door               = 1'b0;
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MSG_BYTES; i++) begin
            if (wr_en && (wr_addr == ADDR_IN_BASE + 8'(i))) begin
                st_d.msg[i] = wr_data;
            end
        end
        if (ack) begin
            st_d.door = 1'b0;
        end
        if (wr_en && (wr_addr == ADDR_DOORBELL)) begin
            st_d.door = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= in_reset();
        else        st_q <= st_d;
    end

    assign in_bytes = st_q.msg;
    assign door     = st_q.door;
endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound
    import mbox_pkg::*;
#(
    parameter int MSG_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               done,
    input  logic [BYTE_W-1:0]                  done_cmd,
    input  logic [WORD_BYTES*BYTE_W-1:0]       done_data,
    input  logic [BYTE_W-1:0]                  done_code,
    output logic [MSG_BYTES-1:0][BYTE_W-1:0]   out_bytes
);
    typedef struct packed {
        logic [MSG_BYTES-1:0][BYTE_W-1:0] msg;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done) begin
            st_d.msg    = '0;
            st_d.msg[0] = done_cmd;
            for (int j = 0; j < WORD_BYTES; j++) begin
                st_d.msg[1 + j] = done_data[BYTE_W*j +: BYTE_W];
            end
            st_d.msg[MSG_BYTES-1] = done_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_bytes = st_q.msg;
endmodule

// File: rtl/mbox_status.sv
module mbox_status
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_status,
    input  logic wr_ctl,
    input  logic clr_bit,
    input  logic en_bit,
    input  logic done,
    output logic alert_sts,
    output logic alert_en,
    output logic irq
);
    typedef struct packed {
        logic alert;
        logic en;
    } sts_st_t;

    sts_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_status && clr_bit) begin
            st_d.alert = 1'b0;
        end
        if (wr_ctl) begin
            st_d.en = en_bit;
        end
        if (done) begin
            st_d.alert = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{alert: 1'b0, en: 1'b1};
        else        st_q <= st_d;
    end

    assign alert_sts = st_q.alert;
    assign alert_en  = st_q.en;
    assign irq       = st_q.alert & st_q.en;
endmodule

// File: rtl/mbox_target_bank.sv
module mbox_target_bank
    import mbox_pkg::*;
#(
    parameter int MSG_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hst_we,
    input  logic                         hst_re,
    input  logic [7:0]                   hst_addr,
    input  logic [7:0]                   hst_wdata,
    output logic [7:0]                   hst_rdata,
    output logic                         fw_req,
    output logic [7:0]                   fw_cmd,
    output logic [WORD_BYTES*8-1:0]      fw_arg,
    input  logic                         fw_ack,
    input  logic                         fw_done,
    input  logic [7:0]                   fw_done_cmd,
    input  logic [WORD_BYTES*8-1:0]      fw_done_data,
    input  logic [7:0]                   fw_done_code,
    output logic                         irq_alert
);
    localparam int IDX_W = $clog2(MSG_BYTES);

    logic [MSG_BYTES-1:0][BYTE_W-1:0] in_bytes;
    logic [MSG_BYTES-1:0][BYTE_W-1:0] out_bytes;
    logic door;
    logic alert_sts, alert_en;

    mbox_inbound #(.MSG_BYTES(MSG_BYTES)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hst_we),
        .wr_addr  (hst_addr),
        .wr_data  (hst_wdata),
        .ack      (fw_ack),
        .in_bytes (in_bytes),
        .door     (door)
    );

    mbox_outbound #(.MSG_BYTES(MSG_BYTES), .WORD_BYTES(WORD_BYTES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (fw_done),
        .done_cmd  (fw_done_cmd),
        .done_data (fw_done_data),
        .done_code (fw_done_code),
        .out_bytes (out_bytes)
    );

    mbox_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_status (hst_we && (hst_addr == ADDR_STATUS)),
        .wr_ctl    (hst_we && (hst_addr == ADDR_ALERT_CTL)),
        .clr_bit   (hst_wdata[ALERT_BIT]),
        .en_bit    (hst_wdata[0]),
        .done      (fw_done),
        .alert_sts (alert_sts),
        .alert_en  (alert_en),
        .irq       (irq_alert)
    );

    assign fw_req = door;
    assign fw_cmd = in_bytes[0];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_arg
        assign fw_arg[8*g +: 8] = in_bytes[1 + g];
    end

    typedef struct packed {
        logic [7:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;
    logic [7:0] off_out, off_in;

    always_comb begin
        rd_d    = rd_q;
        off_out = hst_addr - ADDR_OUT_BASE;
        off_in  = hst_addr - ADDR_IN_BASE;
        if (hst_re) begin
            if (off_out < 8'(MSG_BYTES)) begin
                rd_d.data = out_bytes[off_out[IDX_W-1:0]];
            end else if (off_in < 8'(MSG_BYTES)) begin
                rd_d.data = in_bytes[off_in[IDX_W-1:0]];
            end else begin
                case (hst_addr)
                    ADDR_DOORBELL:  rd_d.data = {7'b0, door};
                    ADDR_STATUS:    rd_d.data = 8'(alert_sts) << ALERT_BIT;
                    ADDR_ALERT_CTL: rd_d.data = {7'b0, alert_en};
                    default:        rd_d.data = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign hst_rdata = rd_q.data;
endmodule

// File: rtl/mbox_target_chk.sv
module mbox_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hst_we,
    input logic [7:0] hst_addr,
    input logic [7:0] hst_wdata,
    input logic       fw_ack,
    input logic       fw_done,
    input logic       fw_req,
    input logic       alert_sts,
    input logic       irq_alert
);
    logic clr_wr, door_wr, ctl_wr;
    assign clr_wr  = hst_we && (hst_addr == 8'h02) && hst_wdata[1];
    assign door_wr = hst_we && (hst_addr == 8'h40);
    assign ctl_wr  = hst_we && (hst_addr == 8'h03);

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fw_done |=> alert_sts);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_sts && !clr_wr) |=> alert_sts);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fw_done) |=> !alert_sts);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && fw_done) |=> alert_sts);

    assert_doorbell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        door_wr |=> (fw_req == $past(hst_wdata[0])));

    assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_ack && !door_wr) |=> !fw_req);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_alert) |-> ($past(fw_done) || $past(ctl_wr)));
endmodule

bind mbox_target_bank mbox_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_we    (hst_we),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .fw_ack    (fw_ack),
    .fw_done   (fw_done),
    .fw_req    (fw_req),
    .alert_sts (alert_sts),
    .irq_alert (irq_alert)
);

// File: tb/sim_mbox_target_bank.sv
`timescale 1ns/1ps
module sim_mbox_target_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we = 1'b0, hst_re = 1'b0;
    logic [7:0]  hst_addr = '0, hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        fw_req, irq_alert;
    logic [7:0]  fw_cmd;
    logic [31:0] fw_arg;
    logic        fw_ack = 1'b0, fw_done = 1'b0;
    logic [7:0]  fw_done_cmd = '0, fw_done_code = '0;
    logic [31:0] fw_done_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    mbox_target_bank u0 (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .fw_req(fw_req), .fw_cmd(fw_cmd), .fw_arg(fw_arg), .fw_ack(fw_ack),
        .fw_done(fw_done), .fw_done_cmd(fw_done_cmd), .fw_done_data(fw_done_data),
        .fw_done_code(fw_done_code), .irq_alert(irq_alert)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        hst_re = 1'b1; hst_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        hst_re = 1'b0;
    endtask

    task automatic done(input logic [7:0] c, input logic [31:0] d, input logic [7:0] code);
        fw_done = 1'b1; fw_done_cmd = c; fw_done_data = d; fw_done_code = code;
        @(negedge clk);
        fw_done = 1'b0;
    endtask

    always @(posedge clk) rd_pend <= hst_re;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("read with no expectation", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), {24'b0, hst_rdata}, {24'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset fw_req", {31'b0, fw_req}, 32'd0);
        check("R10 reset irq", {31'b0, irq_alert}, 32'd0);
        rd(8'h3F, 8'h80, "R1 reset 0x3F");
        rd(8'h38, 8'h00, "R1 reset 0x38");
        rd(8'h02, 8'h00, "R7 reset status");
        rd(8'h03, 8'h01, "R10 reset enable");
        rd(8'h40, 8'h00, "R3 reset doorbell");
        rd(8'h30, 8'h00, "R5 reset outbound");

        wr(8'h38, 8'h3A);
        wr(8'h39, 8'h78); wr(8'h3A, 8'h56); wr(8'h3B, 8'h34); wr(8'h3C, 8'h12);
        check("R2 fw_cmd", {24'b0, fw_cmd}, 32'h3A);
        check("R2 fw_arg", fw_arg, 32'h12345678);
        wr(8'h3E, 8'h5A);
        rd(8'h3C, 8'h12, "R1 readback 0x3C");
        rd(8'h3E, 8'h5A, "R1 readback 0x3E");

        wr(8'h40, 8'h01);
        check("R3 doorbell raise", {31'b0, fw_req}, 32'd1);
        rd(8'h40, 8'h01, "R3 doorbell read");
        wr(8'h40, 8'h00);
        check("R3 doorbell drop", {31'b0, fw_req}, 32'd0);
        wr(8'h40, 8'h01);
        fw_ack = 1'b1; @(negedge clk); fw_ack = 1'b0;
        check("R4 ack clears", {31'b0, fw_req}, 32'd0);
        fw_ack = 1'b1; hst_we = 1'b1; hst_addr = 8'h40; hst_wdata = 8'h01;
        @(negedge clk);
        fw_ack = 1'b0; hst_we = 1'b0;
        check("R4 host write wins", {31'b0, fw_req}, 32'd1);

        done(8'h3A, 32'hDEADBEEF, 8'h03);
        check("R7 irq after done", {31'b0, irq_alert}, 32'd1);
        rd(8'h30, 8'h3A, "R5 echo cmd");
        rd(8'h31, 8'hEF, "R5 data byte0");
        rd(8'h32, 8'hBE, "R5 data byte1");
        rd(8'h33, 8'hAD, "R5 data byte2");
        rd(8'h34, 8'hDE, "R5 data byte3");
        rd(8'h35, 8'h00, "R5 zero 0x35");
        rd(8'h36, 8'h00, "R5 zero 0x36");
        rd(8'h37, 8'h03, "R6 code invalid core");
        rd(8'h02, 8'h02, "R7 status set");
        wr(8'h31, 8'h55);
        rd(8'h31, 8'hEF, "R5 outbound write ignored");

        wr(8'h02, 8'h00);
        rd(8'h02, 8'h02, "R8 zero write keeps");
        check("R7 irq sticky", {31'b0, irq_alert}, 32'd1);
        wr(8'h02, 8'h02);
        check("R8 irq cleared", {31'b0, irq_alert}, 32'd0);
        rd(8'h02, 8'h00, "R8 status cleared");

        wr(8'h03, 8'h00);
        done(8'h11, 32'h0, 8'h00);
        check("R10 masked irq", {31'b0, irq_alert}, 32'd0);
        rd(8'h02, 8'h02, "R10 status kept while masked");
        rd(8'h37, 8'h00, "R6 code success");
        wr(8'h03, 8'h01);
        check("R10 unmask irq", {31'b0, irq_alert}, 32'd1);
        wr(8'h02, 8'h02);

        hst_we = 1'b1; hst_addr = 8'h02; hst_wdata = 8'h02;
        fw_done = 1'b1; fw_done_cmd = 8'h22; fw_done_data = 32'h0; fw_done_code = 8'h02;
        @(negedge clk);
        hst_we = 1'b0; fw_done = 1'b0;
        check("R9 set wins irq", {31'b0, irq_alert}, 32'd1);
        rd(8'h02, 8'h02, "R9 set wins status");
        rd(8'h37, 8'h02, "R6 code unknown command");
        done(8'h23, 32'h0, 8'h01);
        rd(8'h37, 8'h01, "R6 code aborted");

        wr(8'h10, 8'hFF);
        wr(8'h04, 8'hFF);
        rd(8'h10, 8'h00, "R11 unmapped 0x10");
        rd(8'h41, 8'h00, "R11 unmapped 0x41");
        rd(8'h2F, 8'h00, "R11 unmapped 0x2F");
        rd(8'h03, 8'h01, "R11 enable untouched");
        rd(8'h38, 8'h3A, "R11 inbound untouched");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule